// File: doc/BRIEF.md
# Programmable Synthesizer Divider Chain

This block holds the digital counters of a phase-locked frequency synthesizer. It has three of them. A reference divider cuts the reference rate down for the phase comparator. A feedback divider cuts the oscillator rate down for the comparator's other input. A post-scaler sits between the oscillator and the pixel-clock logic that follows it. The loop settles when the oscillator rate equals the reference rate times the feedback modulus divided by the reference modulus.

All three counters run on one fast system clock. Each input edge they count arrives as a single-cycle enable: `ref_ce` for the reference and `vco_ce` for the oscillator. The feedback divider takes the modulus as a plain number and splits it into a swallow count and a main count for a dual-modulus prescaler. The prescaler divides by P+1 for the first A of its cycles and by P for the rest of the M cycles. This gives a modulus of P·M + A, in steps of one, while the programmable counters step only once per prescaler cycle. A doubling control runs the whole count twice per output pulse. No pixel-clock enable reaches the post-scaler, so it keeps running whatever the downstream gating does.

Every counter takes a new setting only at its terminal count. Reprogramming therefore never yields a short or stretched period.

Top module: `pll_div_chain`

## Requirements
- R1: The reference modulus is `ref_div_m1`+1, so any value from 1 to 128 can be set. One `ref_pulse` is produced for every that many `ref_ce` events.
- R2: With `fb_double`=0, a `fb_div` value from 37 to 392 gives one `fb_pulse` per `fb_div` events of `vco_ce`. The period is formed from a prescaler with P=4 that divides by 5 for A = `fb_div` mod 4 cycles and by 4 for the remaining cycles, out of M = `fb_div`/4 cycles.
- R3: A `fb_div` value below 37 is used as 37, and a value above 392 is used as 392.
- R4: With `fb_double`=1, the feedback period is twice the (range-limited) `fb_div` value. This reaches every even modulus from 392 to 784.
- R5: Each `ref_pulse`, `fb_pulse` and `post_tick` lasts exactly one clock cycle. It appears in the cycle after the input event that completes the period, and `fb_pulse` is never high in two consecutive cycles.
- R6: A changed `ref_div_m1`, `fb_div`, `fb_double` or `post_sel` takes effect only at the next terminal count. The period already in progress completes at its old length.
- R7: `post_sel` selects the post-scaler ratio: 00 divides by 1, 01 by 2, 10 by 4 and 11 by 4. One `post_tick` is produced per that many `vco_ce` events, and two ticks are never adjacent when the ratio exceeds 1.
- R8: Counters advance only in cycles where their enable is high. An output pulse only ever follows a cycle in which its enable was high.
- R9: While `rst_n` is low, all outputs are low. Every counter leaves reset at its terminal count, so the first enable event after reset produces a pulse and loads the current setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_ce | input | 1 | One-cycle strobe per reference edge |
| vco_ce | input | 1 | One-cycle strobe per oscillator edge |
| ref_div_m1 | input | 7 | Reference modulus minus one |
| fb_div | input | 9 | Requested feedback modulus |
| fb_double | input | 1 | Doubles the feedback modulus |
| post_sel | input | 2 | Post-scaler ratio select |
| ref_pulse | output | 1 | Reference divider terminal-count pulse |
| fb_pulse | output | 1 | Feedback divider terminal-count pulse |
| post_tick | output | 1 | Post-scaler output tick |

## Verification
The assertions check on every cycle that:
- each output pulse follows an enable cycle;
- feedback pulses are never adjacent;
- the number of `vco_ce` events between feedback pulses stays inside the range 37 to 784;
- reference pulses are no more than 128 reference events apart;
- post-scaler ticks are never adjacent under a ratio above one.

Only the bench's scenarios can show the exact periods for each setting. They also show that values out of range are limited, and that a setting changed mid-period waits for the terminal count. The effect of sparse enable patterns and the state right after reset likewise come only from the bench.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

  typedef enum logic [1:0] {
    POST_BYPASS = 2'b00,
    POST_HALF   = 2'b01,
    POST_QUART  = 2'b10,
    POST_QUART2 = 2'b11
  } post_sel_e;

  // Ratio of the post-scaler for each select code.
  function automatic logic [2:0] post_ratio(input post_sel_e sel);
    logic [2:0] r;
    case (sel)
      POST_BYPASS: r = 3'd1;
      POST_HALF:   r = 3'd2;
      default:     r = 3'd4;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int MOD_MAX = 128,
  localparam int CW     = $clog2(MOD_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_ce,
  input  logic [CW-1:0] mod_m1,
  output logic          pulse
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pulse_q, pulse_d;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (in_ce) begin
      if (cnt_q == '0) begin
        cnt_d   = mod_m1;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/fb_modulus_decode.sv
module fb_modulus_decode #(
  parameter int PRESC = 4,
  parameter int N_MIN = 37,
  parameter int N_MAX = 392,
  localparam int NW   = $clog2(N_MAX + 1),
  localparam int AW   = $clog2(PRESC),
  localparam int MW   = $clog2(N_MAX / PRESC + 1)
) (
  input  logic [NW-1:0] n_req,
  output logic [MW-1:0] m_val,
  output logic [AW-1:0] a_val
);

  logic [NW-1:0] n_lim;

  always_comb begin
    if (n_req < NW'(N_MIN)) begin
      n_lim = NW'(N_MIN);
    end else if (n_req > NW'(N_MAX)) begin
      n_lim = NW'(N_MAX);
    end else begin
      n_lim = n_req;
    end
    m_val = MW'(n_lim >> AW);
    a_val = n_lim[AW-1:0];
  end

endmodule

// File: rtl/fb_divider.sv
module fb_divider #(
  parameter int PRESC = 4,
  parameter int N_MIN = 37,
  parameter int N_MAX = 392,
  localparam int NW   = $clog2(N_MAX + 1),
  localparam int AW   = $clog2(PRESC),
  localparam int MW   = $clog2(N_MAX / PRESC + 1),
  localparam int PCW  = $clog2(PRESC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_ce,
  input  logic [NW-1:0] n_req,
  input  logic          dbl_req,
  output logic          pulse
);

  logic [MW-1:0]  m_new, m_q, m_d, m_sel;
  logic [AW-1:0]  a_new, a_q, a_d, a_sel;
  logic [PCW-1:0] pre_q, pre_d;
  logic [AW-1:0]  sw_q, sw_d, sw_nx;
  logic [MW-1:0]  main_q, main_d;
  logic           dbl_q, dbl_d, half_q, half_d, pulse_q, pulse_d;
  logic           pre_last, main_last, full_end;

  fb_modulus_decode #(
    .PRESC(PRESC), .N_MIN(N_MIN), .N_MAX(N_MAX)
  ) u_dec (
    .n_req(n_req),
    .m_val(m_new),
    .a_val(a_new)
  );

  assign pre_last  = (pre_q == '0);
  assign main_last = (main_q == '0);
  assign full_end  = ~dbl_q | half_q;

  always_comb begin
    pre_d   = pre_q;
    sw_d    = sw_q;
    main_d  = main_q;
    m_d     = m_q;
    a_d     = a_q;
    dbl_d   = dbl_q;
    half_d  = half_q;
    pulse_d = 1'b0;
    a_sel   = a_q;
    m_sel   = m_q;
    sw_nx   = (sw_q != '0) ? sw_q - 1'b1 : '0;
    if (in_ce) begin
      if (!pre_last) begin
        pre_d = pre_q - 1'b1;
      end else if (main_last) begin
        // Terminal count of a full or half period: reload counters.
        if (full_end) begin
          a_sel   = a_new;
          m_sel   = m_new;
          a_d     = a_new;
          m_d     = m_new;
          dbl_d   = dbl_req;
          half_d  = 1'b0;
          pulse_d = 1'b1;
        end else begin
          half_d  = 1'b1;
        end
        sw_d   = a_sel;
        main_d = m_sel - 1'b1;
        pre_d  = (a_sel != '0) ? PCW'(PRESC) : PCW'(PRESC - 1);
      end else begin
        // End of one prescaler cycle inside the period.
        sw_d   = sw_nx;
        main_d = main_q - 1'b1;
        pre_d  = (sw_nx != '0) ? PCW'(PRESC) : PCW'(PRESC - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      sw_q    <= '0;
      main_q  <= '0;
      m_q     <= '0;
      a_q     <= '0;
      dbl_q   <= 1'b0;
      half_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pre_q   <= pre_d;
      sw_q    <= sw_d;
      main_q  <= main_d;
      m_q     <= m_d;
      a_q     <= a_d;
      dbl_q   <= dbl_d;
      half_q  <= half_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/post_scaler.sv
module post_scaler
  import pll_div_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_ce,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [1:0] cnt_q, cnt_d;
  logic       tick_q, tick_d;
  logic [2:0] ratio;

  assign ratio = post_ratio(post_sel_e'(sel));

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (in_ce) begin
      if (cnt_q == 2'd0) begin
        cnt_d  = 2'(ratio - 3'd1);
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain #(
  parameter int REF_MAX = 128,
  parameter int PRESC   = 4,
  parameter int FB_MIN  = 37,
  parameter int FB_MAX  = 392,
  localparam int REF_W  = $clog2(REF_MAX),
  localparam int FB_W   = $clog2(FB_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_ce,
  input  logic             vco_ce,
  input  logic [REF_W-1:0] ref_div_m1,
  input  logic [FB_W-1:0]  fb_div,
  input  logic             fb_double,
  input  logic [1:0]       post_sel,
  output logic             ref_pulse,
  output logic             fb_pulse,
  output logic             post_tick
);

  ref_divider #(.MOD_MAX(REF_MAX)) u_ref (
    .clk   (clk),
    .rst_n (rst_n),
    .in_ce (ref_ce),
    .mod_m1(ref_div_m1),
    .pulse (ref_pulse)
  );

  fb_divider #(.PRESC(PRESC), .N_MIN(FB_MIN), .N_MAX(FB_MAX)) u_fb (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_ce  (vco_ce),
    .n_req  (fb_div),
    .dbl_req(fb_double),
    .pulse  (fb_pulse)
  );

  post_scaler u_post (
    .clk  (clk),
    .rst_n(rst_n),
    .in_ce(vco_ce),
    .sel  (post_sel),
    .tick (post_tick)
  );

endmodule

// File: rtl/pll_div_chain_chk.sv
module pll_div_chain_chk #(
  parameter int REF_MAX = 128,
  parameter int FB_MIN  = 37,
  parameter int FB_MAX  = 392,
  localparam int GW     = $clog2(2 * FB_MAX + 2),
  localparam int RW     = $clog2(REF_MAX + 2)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_ce,
  input logic       vco_ce,
  input logic [1:0] post_sel,
  input logic       ref_pulse,
  input logic       fb_pulse,
  input logic       post_tick
);

  logic [GW-1:0] fb_gap;
  logic [RW-1:0] ref_gap;
  logic          fb_seen, ref_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_gap   <= '0;
      ref_gap  <= '0;
      fb_seen  <= 1'b0;
      ref_seen <= 1'b0;
    end else begin
      if (fb_pulse) begin
        fb_gap  <= vco_ce ? GW'(1) : '0;
        fb_seen <= 1'b1;
      end else if (vco_ce && fb_gap != '1) begin
        fb_gap <= fb_gap + 1'b1;
      end
      if (ref_pulse) begin
        ref_gap  <= ref_ce ? RW'(1) : '0;
        ref_seen <= 1'b1;
      end else if (ref_ce && ref_gap != '1) begin
        ref_gap <= ref_gap + 1'b1;
      end
    end
  end

  assert_ref_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pulse && ref_seen) |-> (ref_gap >= RW'(1) && ref_gap <= RW'(REF_MAX)));

  assert_fb_gap_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && fb_seen) |-> (fb_gap >= GW'(FB_MIN)));

  assert_fb_gap_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && fb_seen) |-> (fb_gap <= GW'(2 * FB_MAX)));

  assert_fb_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  assert_post_spaced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (post_tick && $past(post_sel) != 2'b00) |=> !post_tick);

  assert_ref_on_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> $past(ref_ce));

  assert_fb_on_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> $past(vco_ce));

  assert_post_on_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    post_tick |-> $past(vco_ce));

endmodule

bind pll_div_chain pll_div_chain_chk #(
  .REF_MAX(REF_MAX), .FB_MIN(FB_MIN), .FB_MAX(FB_MAX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_ce   (ref_ce),
  .vco_ce   (vco_ce),
  .post_sel (post_sel),
  .ref_pulse(ref_pulse),
  .fb_pulse (fb_pulse),
  .post_tick(post_tick)
);

// File: tb/pll_div_chain_bench.sv
`timescale 1ns/1ps
module pll_div_chain_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_ce = 1'b0;
  logic       vco_ce = 1'b0;
  logic [6:0] ref_div_m1;
  logic [8:0] fb_div;
  logic       fb_double;
  logic [1:0] post_sel;
  logic       ref_pulse, fb_pulse, post_tick;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  int vgap = 1;
  int rgap = 1;
  int vph = 0;
  int rph = 0;

  // columns: fb_div, fb_double, ref_div_m1, post_sel, exp fb, exp ref, exp post
  localparam int NV = 10;
  localparam int VEC [NV][7] = '{
    '{ 37, 0,   0, 0,  37,   1, 1},
    '{ 38, 0, 127, 1,  38, 128, 2},
    '{100, 0,   5, 2, 100,   6, 4},
    '{392, 0,  63, 3, 392,  64, 4},
    '{200, 1,   1, 0, 400,   2, 1},
    '{392, 1,   2, 1, 784,   3, 2},
    '{ 10, 0,   9, 2,  37,  10, 4},
    '{500, 0,  99, 3, 392, 100, 4},
    '{196, 1, 126, 1, 392, 127, 2},
    '{255, 0,  31, 0, 255,  32, 1}
  };

  pll_div_chain u_pll_div_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_ce    (ref_ce),
    .vco_ce    (vco_ce),
    .ref_div_m1(ref_div_m1),
    .fb_div    (fb_div),
    .fb_double (fb_double),
    .post_sel  (post_sel),
    .ref_pulse (ref_pulse),
    .fb_pulse  (fb_pulse),
    .post_tick (post_tick)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Enable strobes: one strobe every vgap / rgap cycles.
  always @(negedge clk) begin
    vco_ce <= (vph == 0);
    ref_ce <= (rph == 0);
    vph    <= (vph + 1 >= vgap) ? 0 : vph + 1;
    rph    <= (rph + 1 >= rgap) ? 0 : rph + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // which: 0 = ref_pulse, 1 = fb_pulse, 2 = post_tick
  task automatic wait_evt(input int which, output int t);
    do @(negedge clk);
    while (!((which == 0 && ref_pulse) || (which == 1 && fb_pulse) ||
             (which == 2 && post_tick)));
    t = cyc;
  endtask

  task automatic measure(input int which, output int p);
    int t0, t1;
    wait_evt(which, t0);
    wait_evt(which, t0);
    wait_evt(which, t1);
    p = t1 - t0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int p, t0, t1, t2;
    rst_n      = 1'b0;
    ref_div_m1 = 7'd0;
    fb_div     = 9'd37;
    fb_double  = 1'b0;
    post_sel   = 2'b00;
    repeat (3) @(negedge clk);
    // R9: outputs held low in reset
    check("R9 reset ref_pulse", int'(ref_pulse), 0);
    check("R9 reset fb_pulse", int'(fb_pulse), 0);
    check("R9 reset post_tick", int'(post_tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: first event after reset gives a pulse from every counter
    check("R9 first ref_pulse", int'(ref_pulse), 1);
    check("R9 first fb_pulse", int'(fb_pulse), 1);
    check("R9 first post_tick", int'(post_tick), 1);

    // Table walk: R1, R2, R3, R4, R7
    for (int i = 0; i < NV; i++) begin
      string rq;
      fb_div     = 9'(VEC[i][0]);
      fb_double  = VEC[i][1][0];
      ref_div_m1 = 7'(VEC[i][2]);
      post_sel   = 2'(VEC[i][3]);
      if (VEC[i][1] != 0) rq = "R4 feedback doubled";
      else if (VEC[i][0] < 37 || VEC[i][0] > 392) rq = "R3 feedback limited";
      else rq = "R2 feedback modulus";
      measure(1, p);
      check(rq, p, VEC[i][4]);
      measure(0, p);
      check("R1 reference modulus", p, VEC[i][5]);
      measure(2, p);
      check("R7 post ratio", p, VEC[i][6]);
    end

    // R5: single-cycle feedback pulse
    fb_div = 9'd60; fb_double = 1'b0;
    wait_evt(1, t0);
    @(negedge clk);
    check("R5 fb_pulse width", int'(fb_pulse), 0);

    // R6: feedback change mid-period
    fb_div = 9'd100;
    measure(1, p);
    wait_evt(1, t0);
    repeat (10) @(negedge clk);
    fb_div = 9'd50;
    wait_evt(1, t1);
    check("R6 fb period in flight", t1 - t0, 100);
    wait_evt(1, t2);
    check("R6 fb new period", t2 - t1, 50);

    // R6: doubling request mid-period
    wait_evt(1, t0);
    repeat (3) @(negedge clk);
    fb_double = 1'b1;
    wait_evt(1, t1);
    check("R6 double in flight", t1 - t0, 50);
    wait_evt(1, t2);
    check("R6 double applied", t2 - t1, 100);
    fb_double = 1'b0;

    // R6: reference change mid-period
    ref_div_m1 = 7'd39;
    measure(0, p);
    wait_evt(0, t0);
    repeat (5) @(negedge clk);
    ref_div_m1 = 7'd9;
    wait_evt(0, t1);
    check("R6 ref period in flight", t1 - t0, 40);
    wait_evt(0, t2);
    check("R6 ref new period", t2 - t1, 10);

    // R6: post-scaler change mid-period
    post_sel = 2'b10;
    measure(2, p);
    wait_evt(2, t0);
    @(negedge clk);
    post_sel = 2'b00;
    wait_evt(2, t1);
    check("R6 post period in flight", t1 - t0, 4);
    wait_evt(2, t2);
    check("R6 post new period", t2 - t1, 1);

    // R8: sparse enables
    vgap = 3; rgap = 2;
    fb_div = 9'd40; post_sel = 2'b01; ref_div_m1 = 7'd4;
    measure(1, p);
    check("R8 fb with sparse vco_ce", p, 120);
    measure(2, p);
    check("R8 post with sparse vco_ce", p, 6);
    measure(0, p);
    check("R8 ref with sparse ref_ce", p, 10);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule